// File: doc/BRIEF.md
# Dual Reload PWM Timer

This timer produces a pulse-width modulated signal from two separate reload values. A single down-counter runs a high phase that lasts `reload_m`+1 ticks and then a low phase that lasts `reload_n`+1 ticks, and this repeats for as long as the run input is set. Beside it, an independent ON counter counts down from its own reload value. It reloads when it reaches zero and flags each reload for one clock.

Every register sits on the fast clock. The slower time base arrives as a single-cycle enable pulse (`slow_tick`, nominally 32 kHz) and is never used as a clock. A select input picks the time base. A bypass input decides whether the ON counter sees every selected tick or only every tenth one. The phase counter always sees every selected tick. In one output mode the signal is a steady 1 during the high phase. In the other it carries half the fast clock during the high phase. Reset is asynchronous and active low, and is expected to be released in step with the clock by the reset logic upstream.

Top module: `dual_reload_pwm_timer`

## Requirements
- R1: While reset is asserted, and after it is released with `run` low, `pwm_out`, `phase_cnt`, `on_cnt` and `on_wrap` are all 0.
- R2: A clock edge that sees `run` at 0 clears every counter, the prescaler, `pwm_out` and `on_wrap`. When `run` returns to 1, the sequence starts again from its beginning.
- R3: The first selected tick after `run` goes high loads `reload_m` and enters the high phase. The high phase lasts `reload_m`+1 ticks and the low phase lasts `reload_n`+1 ticks, and the two alternate.
- R4: `phase_cnt` shows the live phase counter: `reload_m` down to 0 during the high phase, then `reload_n` down to 0 during the low phase.
- R5: With `clk_sel` at 1 every clock is a tick. With `clk_sel` at 0, counters advance only on clocks where `slow_tick` is 1.
- R6: The first ON tick loads `reload_on` into the ON counter. Each later ON tick decrements it, and an ON tick at 0 reloads it, so the period is `reload_on`+1 ON ticks. `on_cnt` shows the live value.
- R7: `on_wrap` is 1 for exactly the clock cycle that follows an edge on which the ON counter reloaded, and 0 at all other times.
- R8: With `on_div_bypass` at 0, the ON counter advances only on the 10th, 20th, 30th, ... selected tick counted since `run` rose. The phase counter still advances on every selected tick.
- R9: With `pwm_mode` at 0, `pwm_out` is 1 on every clock of the high phase.
- R10: With `pwm_mode` at 1, `pwm_out` is 0 on the first clock of each high phase and then inverts on every clock until the high phase ends.
- R11: `pwm_out` is 0 whenever the timer is not in the high phase.
- R12: With `reload_m` = `reload_n` = 0, each phase lasts one tick. With `reload_on` = 0, the ON counter reloads and flags on every ON tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Single-cycle pulse marking each slow time-base tick |
| run | input | 1 | 1 runs the timer, 0 holds it cleared |
| clk_sel | input | 1 | 1 selects the fast clock as tick, 0 selects `slow_tick` |
| on_div_bypass | input | 1 | 1 feeds every tick to the ON counter, 0 feeds every tenth |
| pwm_mode | input | 1 | 0 steady high output, 1 half fast clock during high phase |
| reload_m | input | CNT_W | High-phase reload value |
| reload_n | input | CNT_W | Low-phase reload value |
| reload_on | input | CNT_W | ON counter reload value |
| pwm_out | output | 1 | PWM output |
| phase_cnt | output | CNT_W | Live phase counter value |
| on_cnt | output | CNT_W | Live ON counter value |
| on_wrap | output | 1 | One-clock flag after an ON counter reload |

## Verification
The properties assume that the three reload values, `clk_sel`, `on_div_bypass` and `pwm_mode` change only while `run` is 0. They also assume that `slow_tick` is a clean single-clock pulse, because a reload or select that changes mid-phase would make the phase-entry and reload checks compare against a value the counter never loaded. The stimulus honours this by applying each new configuration on a cycle with `run` low before starting the run. It generates `slow_tick` as isolated one-cycle pulses at a fixed spacing. The expected waveform comes from tick counts derived from the requirements, and each configuration covers several full high/low and ON periods.

// File: rtl/drt_pkg.sv
package drt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;
endpackage

// File: rtl/drt_tick_gen.sv
module drt_tick_gen #(
  parameter int PRE_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clk_sel,
  input  logic slow_tick,
  input  logic on_div_bypass,
  output logic phase_tick,
  output logic on_tick
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             base_tick;
  logic             pre_last;

  assign base_tick  = clk_sel | slow_tick;
  assign pre_last   = (pre_q == PRE_LAST);
  assign phase_tick = run & base_tick;
  assign on_tick    = run & base_tick & (on_div_bypass | pre_last);

  always_comb begin
    pre_d = pre_q;
    if (!run) begin
      pre_d = '0;
    end else if (base_tick) begin
      pre_d = pre_last ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/drt_phase_ctr.sv
module drt_phase_ctr
  import drt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_m,
  input  logic [CNT_W-1:0] reload_n,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!run) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (tick) begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_HIGH;
          cnt_d   = reload_m;
        end
        PH_HIGH: begin
          if (at_zero) begin
            phase_d = PH_LOW;
            cnt_d   = reload_n;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_LOW: begin
          if (at_zero) begin
            phase_d = PH_HIGH;
            cnt_d   = reload_m;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;
endmodule

// File: rtl/drt_on_ctr.sv
module drt_on_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload_on,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        cnt_d  = reload_on;
        wrap_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt  = cnt_q;
  assign wrap = wrap_q;
endmodule

// File: rtl/dual_reload_pwm_timer.sv
module dual_reload_pwm_timer
  import drt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             run,
  input  logic             clk_sel,
  input  logic             on_div_bypass,
  input  logic             pwm_mode,
  input  logic [CNT_W-1:0] reload_m,
  input  logic [CNT_W-1:0] reload_n,
  input  logic [CNT_W-1:0] reload_on,
  output logic             pwm_out,
  output logic [CNT_W-1:0] phase_cnt,
  output logic [CNT_W-1:0] on_cnt,
  output logic             on_wrap
);
  logic   phase_tick;
  logic   on_tick;
  phase_e phase;
  logic   tgl_q, tgl_d;
  logic   in_high;

  drt_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .clk_sel       (clk_sel),
    .slow_tick     (slow_tick),
    .on_div_bypass (on_div_bypass),
    .phase_tick    (phase_tick),
    .on_tick       (on_tick)
  );

  drt_phase_ctr #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (phase_tick),
    .reload_m (reload_m),
    .reload_n (reload_n),
    .phase    (phase),
    .cnt      (phase_cnt)
  );

  drt_on_ctr #(.CNT_W(CNT_W)) u_on (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (on_tick),
    .reload_on (reload_on),
    .cnt       (on_cnt),
    .wrap      (on_wrap)
  );

  assign in_high = (phase == PH_HIGH);

  // half-rate toggle, restarted at 0 on entry to each high phase
  always_comb begin
    tgl_d = in_high ? ~tgl_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_d;
  end

  assign pwm_out = in_high & (pwm_mode ? tgl_q : 1'b1);
endmodule

// File: rtl/drt_checker.sv
module drt_checker
  import drt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             clk_sel,
  input logic             slow_tick,
  input logic             pwm_mode,
  input logic [CNT_W-1:0] reload_m,
  input logic [CNT_W-1:0] reload_n,
  input logic [CNT_W-1:0] reload_on,
  input phase_e           phase,
  input logic             pwm_out,
  input logic [CNT_W-1:0] phase_cnt,
  input logic [CNT_W-1:0] on_cnt,
  input logic             on_wrap
);
  logic sel_tick;
  assign sel_tick = clk_sel | slow_tick;

  p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase_cnt == '0 && on_cnt == '0 && !pwm_out && !on_wrap));

  p_high_to_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel_tick && phase == PH_HIGH && phase_cnt == '0)
      |=> (phase == PH_LOW && phase_cnt == $past(reload_n)));

  p_low_to_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel_tick && phase == PH_LOW && phase_cnt == '0)
      |=> (phase == PH_HIGH && phase_cnt == $past(reload_m)));

  p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sel_tick) |=> ($stable(phase_cnt) && $stable(on_cnt)));

  p_wrap_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    on_wrap |-> (on_cnt == reload_on));

  p_steady_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH && !pwm_mode) |-> pwm_out);

  p_toggle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && $past(pwm_mode) && phase == PH_HIGH && $past(phase) == PH_HIGH)
      |-> (pwm_out != $past(pwm_out)));

  p_quiet_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_HIGH) |-> !pwm_out);
endmodule

bind dual_reload_pwm_timer drt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .clk_sel   (clk_sel),
  .slow_tick (slow_tick),
  .pwm_mode  (pwm_mode),
  .reload_m  (reload_m),
  .reload_n  (reload_n),
  .reload_on (reload_on),
  .phase     (phase),
  .pwm_out   (pwm_out),
  .phase_cnt (phase_cnt),
  .on_cnt    (on_cnt),
  .on_wrap   (on_wrap)
);

// File: tb/dual_reload_pwm_timer_bench.sv
`timescale 1ns/1ps
module dual_reload_pwm_timer_bench;
  localparam int CNT_W = 16;

  typedef struct {
    logic             pwm;
    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] ocnt;
    logic             wrap;
    string            tag;
  } item_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             slow_tick;
  logic             run;
  logic             clk_sel;
  logic             on_div_bypass;
  logic             pwm_mode;
  logic [CNT_W-1:0] reload_m;
  logic [CNT_W-1:0] reload_n;
  logic [CNT_W-1:0] reload_on;
  logic             pwm_out;
  logic [CNT_W-1:0] phase_cnt;
  logic [CNT_W-1:0] on_cnt;
  logic             on_wrap;

  int checks = 0;
  int errors = 0;
  item_t exp_q[$];

  // reference state, derived from tick counts
  int  k_ticks = 0;
  int  j_ticks = 0;
  int  hi_cyc  = 0;
  bit  prev_high = 1'b0;
  int  cm = 0, cn = 0, con = 0;

  always #2.5 clk = ~clk;

  dual_reload_pwm_timer u_dual_reload_pwm_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .slow_tick     (slow_tick),
    .run           (run),
    .clk_sel       (clk_sel),
    .on_div_bypass (on_div_bypass),
    .pwm_mode      (pwm_mode),
    .reload_m      (reload_m),
    .reload_n      (reload_n),
    .reload_on     (reload_on),
    .pwm_out       (pwm_out),
    .phase_cnt     (phase_cnt),
    .on_cnt        (on_cnt),
    .on_wrap       (on_wrap)
  );

  // monitor: pop one expected item per clock, just after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      checks++;
      if (pwm_out !== e.pwm || phase_cnt !== e.pcnt ||
          on_cnt !== e.ocnt || on_wrap !== e.wrap) begin
        errors++;
        $display("FAIL %s: pwm/phase/on/wrap actual %0b/%0d/%0d/%0b expected %0b/%0d/%0d/%0b",
                 e.tag, pwm_out, phase_cnt, on_cnt, on_wrap,
                 e.pwm, e.pcnt, e.ocnt, e.wrap);
      end
    end
  end

  // driver: one clock of stimulus plus the expected state after the edge
  task automatic cyc(input bit run_v, input bit st, input string tag);
    item_t e;
    bit    tick, on_t, high;
    int    i, pos, pc, oc;
    @(negedge clk);
    run       = run_v;
    slow_tick = st;
    on_t      = 1'b0;
    if (!run_v) begin
      k_ticks = 0; j_ticks = 0; hi_cyc = 0; prev_high = 1'b0;
      e.pwm = 1'b0; e.pcnt = '0; e.ocnt = '0; e.wrap = 1'b0;
    end else begin
      tick = clk_sel | st;
      if (tick) begin
        k_ticks++;
        if (on_div_bypass || (k_ticks % 10 == 0)) begin
          j_ticks++;
          on_t = 1'b1;
        end
      end
      high = 1'b0; pc = 0;
      if (k_ticks > 0) begin
        i = (k_ticks - 1) % (cm + cn + 2);
        high = (i <= cm);
        pc = high ? (cm - i) : (cn - (i - cm - 1));
      end
      oc = 0; pos = 1;
      if (j_ticks > 0) begin
        pos = (j_ticks - 1) % (con + 1);
        oc  = con - pos;
      end
      if (high) hi_cyc = prev_high ? hi_cyc + 1 : 0;
      prev_high = high;
      e.pwm  = high && (pwm_mode ? hi_cyc[0] : 1'b1);
      e.pcnt = CNT_W'(pc);
      e.ocnt = CNT_W'(oc);
      e.wrap = on_t && (pos == 0);
    end
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic configure(input int m, input int n, input int on, input bit sel,
                           input bit byp, input bit mode);
    @(negedge clk);
    run = 1'b0;
    cm = m; cn = n; con = on;
    reload_m = CNT_W'(m); reload_n = CNT_W'(n); reload_on = CNT_W'(on);
    clk_sel = sel; on_div_bypass = byp; pwm_mode = mode;
    cyc(1'b0, 1'b0, "R2 idle");
  endtask

  task automatic run_for(input int n, input int slow_every, input string tag);
    for (int c = 0; c < n; c++) begin
      cyc(1'b1, (slow_every > 0) && (c % slow_every == 0), tag);
    end
  endtask

  task automatic drain;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; slow_tick = 1'b0; clk_sel = 1'b0;
    on_div_bypass = 1'b0; pwm_mode = 1'b0;
    reload_m = '0; reload_n = '0; reload_on = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (pwm_out !== 1'b0 || phase_cnt !== '0 || on_cnt !== '0 || on_wrap !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs actual %0b/%0d/%0d/%0b expected 0/0/0/0",
               pwm_out, phase_cnt, on_cnt, on_wrap);
    end
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, "R1 after release");

    // R3 R4 R6 R7 R9 R11: fast ticks, steady output
    configure(3, 2, 4, 1'b1, 1'b1, 1'b0);
    run_for(40, 0, "R3 R4 R6 R7 R9 R11");

    // R2: stop mid-run, then restart from the beginning
    run_for(3, 0, "R3");
    cyc(1'b0, 1'b0, "R2");
    cyc(1'b0, 1'b0, "R2");
    run_for(12, 0, "R2 restart");

    // R10: half fast clock during the high phase
    configure(5, 1, 3, 1'b1, 1'b1, 1'b1);
    run_for(30, 0, "R10 R11");

    // R5: slow time base, one pulse every third clock
    configure(2, 1, 3, 1'b0, 1'b1, 1'b0);
    run_for(45, 3, "R5");

    // R8: ON counter on every tenth tick only
    configure(1, 1, 2, 1'b1, 1'b0, 1'b0);
    run_for(80, 0, "R8");

    // R8 with slow ticks and mode 1
    configure(3, 3, 1, 1'b0, 1'b0, 1'b1);
    run_for(90, 2, "R8 R5 R10");

    // R12: single-tick phases and reload every ON tick
    configure(0, 0, 0, 1'b1, 1'b1, 1'b0);
    run_for(12, 0, "R12");
    configure(0, 0, 0, 1'b1, 1'b1, 1'b1);
    run_for(8, 0, "R12 R10");

    configure(0, 0, 0, 1'b1, 1'b1, 1'b0);
    drain();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule